// File: doc/BRIEF.md
# Endpoint Interrupt Aggregator with End-of-Interrupt Gate

This block collects the interrupt events of a USB OTG core into one 32-bit raw source register and drives a single interrupt line towards the CPU. Each transmit endpoint, each receive endpoint and each core-level USB event owns one sticky bit. Software reads the raw sources, the enable mask, or the masked view through a small 32-bit register bus. Bits are changed only through dedicated write-one-to-set and write-one-to-clear aliases. Writing the set alias lets software inject an event by hand, for example a VBUS-drive change that starts a polling routine.

The interrupt line gives a one-cycle pulse when an enabled source is pending. After that pulse the line stays quiet, even for new or remaining events, until software writes the end-of-interrupt register. A handler therefore reads the masked view, clears what it serviced through the clear alias and then writes end-of-interrupt. If anything is still pending at that point, a fresh pulse follows at once.

Top module: `irq_shadow_wrap`

## Requirements
- R1: Event inputs map to fixed source bits. tx_evt[i] maps to bit i (bits 0 to 4, endpoint 0 and four transmit endpoints). rx_evt[j] maps to bit 9+j (receive endpoints 1 to 4 on bits 9 to 12). core_evt[k] maps to bit 16+k (bits 16 to 24), and core_evt[8], the VBUS-drive change, lands on bit 24. All other bits of the source and the mask read 0 and cannot be set.
- R2: A one-cycle event pulse sets its source bit at the next clock edge. The bit stays set until software clears it.
- R3: A write to offset 0x24 sets every source bit that is 1 in the write data. Offset 0x20 reads the raw source.
- R4: A write to offset 0x28 clears every source bit that is 1 in the write data. When a hardware event hits a bit in the same cycle as its clear, the bit ends up set.
- R5: A write to offset 0x30 sets mask bits and a write to offset 0x34 clears mask bits. Offset 0x2C reads the mask.
- R6: Offset 0x38 reads the raw source ANDed with the mask.
- R7: Writes to 0x20, 0x2C and 0x38 change nothing. Reads of 0x24, 0x28, 0x30, 0x34 and 0x3C return 0.
- R8: When the masked source is non-zero and the gate is open, irq_o is high for exactly one cycle, starting one clock edge after the condition is registered. The pulse closes the gate.
- R9: Once the gate is closed, irq_o stays low until a write to offset 0x3C, whatever its data. If the masked source is still non-zero, the pulse comes one edge after that write.
- R10: Reset clears the source and the mask, opens the gate and holds irq_o low.
- R11: Events whose mask bit is 0 never raise irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wen | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| tx_evt | input | TX_N | Transmit endpoint event pulses |
| rx_evt | input | RX_N | Receive endpoint 1..4 event pulses |
| core_evt | input | CORE_N | Core USB event pulses |
| irq_o | output | 1 | Interrupt pulse to the CPU |

## Verification
The hardest case to reach is a closed gate with enabled sources still pending. The design gives no visible sign of it, because irq_o simply stays low. The stimulus first fires a pulse, then adds a new event and enables it, and watches that the line stays quiet over several cycles. It then writes end-of-interrupt with arbitrary data and expects the pulse on the exact cycle. A clear write that lands on the same edge as an event on the same bit is produced by driving both from one task in the same cycle.

// File: rtl/irqw_pkg.sv
package irqw_pkg;

    localparam int DATA_W   = 32;
    localparam int TX_LSB   = 0;
    localparam int RX_LSB   = 9;
    localparam int CORE_LSB = 16;

    // Register offsets (software visible, fixed)
    localparam logic [7:0] OFS_SRC      = 8'h20;
    localparam logic [7:0] OFS_SRC_SET  = 8'h24;
    localparam logic [7:0] OFS_SRC_CLR  = 8'h28;
    localparam logic [7:0] OFS_MSK      = 8'h2C;
    localparam logic [7:0] OFS_MSK_SET  = 8'h30;
    localparam logic [7:0] OFS_MSK_CLR  = 8'h34;
    localparam logic [7:0] OFS_MASKED   = 8'h38;
    localparam logic [7:0] OFS_EOI      = 8'h3C;

    typedef struct packed {
        logic src_set;
        logic src_clr;
        logic msk_set;
        logic msk_clr;
        logic eoi;
    } irqw_wstb_t;

    typedef struct packed {
        logic [DATA_W-1:0] src;
        logic [DATA_W-1:0] mask;
        logic              gate_open;
        logic              irq;
    } irqw_state_t;

    function automatic logic [DATA_W-1:0] field_bits(input int lsb, input int n);
        logic [DATA_W-1:0] v;
        v = '0;
        for (int i = 0; i < n; i++) v[lsb+i] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/irqw_evt_pack.sv
module irqw_evt_pack
    import irqw_pkg::*;
#(
    parameter int TX_N   = 5,
    parameter int RX_N   = 4,
    parameter int CORE_N = 9
) (
    input  logic [TX_N-1:0]   tx_evt,
    input  logic [RX_N-1:0]   rx_evt,
    input  logic [CORE_N-1:0] core_evt,
    output logic [DATA_W-1:0] evt_vec
);

    // R1: fixed placement of each event group in the source word
    always_comb begin
        evt_vec = '0;
        for (int i = 0; i < TX_N; i++)   evt_vec[TX_LSB+i]   = tx_evt[i];
        for (int j = 0; j < RX_N; j++)   evt_vec[RX_LSB+j]   = rx_evt[j];
        for (int k = 0; k < CORE_N; k++) evt_vec[CORE_LSB+k] = core_evt[k];
    end

endmodule

// File: rtl/irqw_decode.sv
module irqw_decode
    import irqw_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              bus_wen,
    input  logic [ADDR_W-1:0] bus_addr,
    output irqw_wstb_t        wstb
);

    always_comb begin
        wstb         = '0;
        wstb.src_set = bus_wen && (bus_addr == ADDR_W'(OFS_SRC_SET));
        wstb.src_clr = bus_wen && (bus_addr == ADDR_W'(OFS_SRC_CLR));
        wstb.msk_set = bus_wen && (bus_addr == ADDR_W'(OFS_MSK_SET));
        wstb.msk_clr = bus_wen && (bus_addr == ADDR_W'(OFS_MSK_CLR));
        wstb.eoi     = bus_wen && (bus_addr == ADDR_W'(OFS_EOI));
    end

endmodule

// File: rtl/irqw_rdmux.sv
module irqw_rdmux
    import irqw_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] rdata
);

    // R6 / R7: readable views; aliases and EOI read as zero
    always_comb begin
        rdata = '0;
        if (bus_addr == ADDR_W'(OFS_SRC))    rdata = src;
        if (bus_addr == ADDR_W'(OFS_MSK))    rdata = mask;
        if (bus_addr == ADDR_W'(OFS_MASKED)) rdata = src & mask;
    end

endmodule

// File: rtl/irq_shadow_wrap.sv
module irq_shadow_wrap
    import irqw_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int TX_N   = 5,
    parameter int RX_N   = 4,
    parameter int CORE_N = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [TX_N-1:0]   tx_evt,
    input  logic [RX_N-1:0]   rx_evt,
    input  logic [CORE_N-1:0] core_evt,
    output logic              irq_o
);

    localparam logic [DATA_W-1:0] VALID =
        field_bits(TX_LSB, TX_N) | field_bits(RX_LSB, RX_N) | field_bits(CORE_LSB, CORE_N);

    irqw_state_t       st_d, st_q;
    irqw_wstb_t        wstb;
    logic [DATA_W-1:0] evt_vec;
    logic [DATA_W-1:0] src_q;
    logic [DATA_W-1:0] mask_q;

    irqw_evt_pack #(.TX_N(TX_N), .RX_N(RX_N), .CORE_N(CORE_N)) u_pack (
        .tx_evt   (tx_evt),
        .rx_evt   (rx_evt),
        .core_evt (core_evt),
        .evt_vec  (evt_vec)
    );

    irqw_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_wen  (bus_wen),
        .bus_addr (bus_addr),
        .wstb     (wstb)
    );

    irqw_rdmux #(.ADDR_W(ADDR_W)) u_rd (
        .bus_addr (bus_addr),
        .src      (src_q),
        .mask     (mask_q),
        .rdata    (bus_rdata)
    );

    always_comb begin
        logic [DATA_W-1:0] src_n;
        logic [DATA_W-1:0] msk_n;
        logic              fire;
        st_d  = st_q;
        // R3 / R4 / R2: clear, then set, then hardware events (events win)
        src_n = st_q.src;
        if (wstb.src_clr) src_n = src_n & ~bus_wdata;
        if (wstb.src_set) src_n = src_n | bus_wdata;
        src_n    = (src_n | evt_vec) & VALID;
        st_d.src = src_n;
        // R5: mask aliases
        msk_n = st_q.mask;
        if (wstb.msk_clr) msk_n = msk_n & ~bus_wdata;
        if (wstb.msk_set) msk_n = msk_n | bus_wdata;
        st_d.mask = msk_n & VALID;
        // R8 / R9: single pulse gated by end-of-interrupt
        fire     = st_q.gate_open && (|(st_q.src & st_q.mask));
        st_d.irq = fire;
        if (fire)          st_d.gate_open = 1'b0;
        else if (wstb.eoi) st_d.gate_open = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.gate_open <= 1'b1;   // R10
        end else begin
            st_q <= st_d;
        end
    end

    assign src_q  = st_q.src;
    assign mask_q = st_q.mask;
    assign irq_o  = st_q.irq;

endmodule

// File: rtl/irqw_checker.sv
module irqw_checker
    import irqw_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wen,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] evt_vec,
    input logic [DATA_W-1:0] src_q,
    input logic [DATA_W-1:0] mask_q,
    input logic              irq_o
);

    logic past_ok_q;
    logic blocked_q;
    logic clr_wr, msk_wr, eoi_wr;

    assign clr_wr = bus_wen && (bus_addr == ADDR_W'(OFS_SRC_CLR));
    assign msk_wr = bus_wen && ((bus_addr == ADDR_W'(OFS_MSK_SET)) || (bus_addr == ADDR_W'(OFS_MSK_CLR)));
    assign eoi_wr = bus_wen && (bus_addr == ADDR_W'(OFS_EOI));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok_q <= 1'b0;
            blocked_q <= 1'b0;
        end else begin
            past_ok_q <= 1'b1;
            if (eoi_wr)     blocked_q <= 1'b0;
            else if (irq_o) blocked_q <= 1'b1;
        end
    end

    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q |-> ((src_q & $past(evt_vec)) == $past(evt_vec)));

    assert_clear_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && !$past(clr_wr)) |-> ((src_q & $past(src_q)) == $past(src_q)));

    assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && !$past(msk_wr)) |-> (mask_q == $past(mask_q)));

    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && irq_o) |-> $past(|(src_q & mask_q)));

    assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    assert_eoi_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !blocked_q);

endmodule

bind irq_shadow_wrap irqw_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wen  (bus_wen),
    .bus_addr (bus_addr),
    .evt_vec  (evt_vec),
    .src_q    (src_q),
    .mask_q   (mask_q),
    .irq_o    (irq_o)
);

// File: tb/tb_irq_shadow_wrap.sv
module tb_irq_shadow_wrap;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  tx_evt = '0;
    logic [3:0]  rx_evt = '0;
    logic [8:0]  core_evt = '0;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    irq_shadow_wrap dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_evt(tx_evt),
        .rx_evt(rx_evt), .core_evt(core_evt), .irq_o(irq_o)
    );

    typedef struct packed {
        logic        rd;
        logic [7:0]  a;
        logic [31:0] d;
        logic [31:0] e;
        logic [3:0]  r;
    } tvec_t;

    // rd=1: read a and compare with e; rd=0: write d to a
    localparam tvec_t TBL [20] = '{
        '{1'b0, 8'h24, 32'hFFFF_FFFF, 32'h0, 4'd3},
        '{1'b1, 8'h20, 32'h0, 32'h01FF_1E1F, 4'd1},   // R1 R3
        '{1'b0, 8'h28, 32'h0000_001F, 32'h0, 4'd4},
        '{1'b1, 8'h20, 32'h0, 32'h01FF_1E00, 4'd4},   // R4
        '{1'b0, 8'h20, 32'h0, 32'h0, 4'd7},
        '{1'b1, 8'h20, 32'h0, 32'h01FF_1E00, 4'd7},   // R7
        '{1'b1, 8'h24, 32'h0, 32'h0, 4'd7},           // R7
        '{1'b0, 8'h30, 32'h0000_1F03, 32'h0, 4'd5},
        '{1'b1, 8'h2C, 32'h0, 32'h0000_1E03, 4'd5},   // R5
        '{1'b1, 8'h38, 32'h0, 32'h0000_1E00, 4'd6},   // R6
        '{1'b0, 8'h2C, 32'hFFFF_FFFF, 32'h0, 4'd7},
        '{1'b1, 8'h2C, 32'h0, 32'h0000_1E03, 4'd7},   // R7
        '{1'b0, 8'h34, 32'h0000_0A00, 32'h0, 4'd5},
        '{1'b1, 8'h2C, 32'h0, 32'h0000_1403, 4'd5},   // R5
        '{1'b0, 8'h38, 32'h0, 32'h0, 4'd7},
        '{1'b1, 8'h38, 32'h0, 32'h0000_1400, 4'd6},   // R6
        '{1'b0, 8'h28, 32'hFFFF_FFFF, 32'h0, 4'd4},
        '{1'b1, 8'h20, 32'h0, 32'h0, 4'd4},           // R4
        '{1'b1, 8'h3C, 32'h0, 32'h0, 4'd7},           // R7
        '{1'b1, 8'h34, 32'h0, 32'h0, 4'd7}            // R7
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] e);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, e);
    endtask

    task automatic evt(input logic [4:0] t, input logic [3:0] r, input logic [8:0] c);
        @(negedge clk);
        tx_evt = t; rx_evt = r; core_evt = c;
        @(negedge clk);
        tx_evt = '0; rx_evt = '0; core_evt = '0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        chk("R10 irq in reset", {31'b0, irq_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_chk("R10 source after reset", 8'h20, 32'h0);
        rd_chk("R10 mask after reset", 8'h2C, 32'h0);
        chk("R10 irq after reset", {31'b0, irq_o}, 32'h0);

        // Register table
        foreach (TBL[i]) begin
            if (TBL[i].rd) rd_chk($sformatf("R%0d table[%0d]", TBL[i].r, i), TBL[i].a, TBL[i].e);
            else wr(TBL[i].a, TBL[i].d);
        end

        // Fresh start for the interrupt path
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 irq after second reset", {31'b0, irq_o}, 32'h0);
        rst_n = 1'b1;

        // R2 / R1: hardware pulses, sticky
        evt(5'b00100, 4'b0001, 9'h100);
        rd_chk("R2 R1 sticky source", 8'h20, 32'h0100_0204);
        repeat (3) @(negedge clk);
        rd_chk("R2 source held", 8'h20, 32'h0100_0204);
        // R11: mask is zero, no interrupt
        chk("R11 masked-out no irq", {31'b0, irq_o}, 32'h0);

        // R8: enable bit 24 -> single pulse one edge later
        wr(8'h30, 32'h0100_0000);
        chk("R8 irq not yet", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        chk("R8 irq pulse", {31'b0, irq_o}, 32'h1);
        @(negedge clk);
        chk("R8 irq single cycle", {31'b0, irq_o}, 32'h0);

        // R9: new enabled event while gate closed stays silent
        evt(5'b00001, 4'b0000, 9'h000);
        wr(8'h30, 32'h0000_0001);
        repeat (4) begin
            @(negedge clk);
            chk("R9 blocked before EOI", {31'b0, irq_o}, 32'h0);
        end

        // R4: clear on same edge as event on bit 1; bit 0 really cleared
        @(negedge clk);
        bus_addr = 8'h28; bus_wdata = 32'h0000_0003; bus_wen = 1'b1; tx_evt = 5'b00010;
        @(negedge clk);
        bus_wen = 1'b0; tx_evt = '0;
        rd_chk("R4 event beats clear", 8'h20, 32'h0100_0206);
        rd_chk("R6 masked view", 8'h38, 32'h0100_0000);

        // R9: EOI with arbitrary data reopens gate, pending gives a pulse
        wr(8'h3C, 32'hDEAD_BEEF);
        chk("R9 irq one edge after EOI not yet", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        chk("R9 irq after EOI", {31'b0, irq_o}, 32'h1);
        @(negedge clk);
        chk("R9 irq falls", {31'b0, irq_o}, 32'h0);

        // R11: clear all, disable bit 24, EOI, new masked-out event -> quiet
        wr(8'h28, 32'hFFFF_FFFF);
        wr(8'h34, 32'hFFFF_FFFF);
        wr(8'h3C, 32'h0);
        evt(5'b11111, 4'b1111, 9'h1FF);
        repeat (3) begin
            @(negedge clk);
            chk("R11 no irq with mask clear", {31'b0, irq_o}, 32'h0);
        end
        rd_chk("R1 all event inputs", 8'h20, 32'h01FF_1E1F);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule